// File: doc/BRIEF.md
# Byte Port with Strobe/Ready Interlock

This block moves bytes across a parallel port. Two handshake wires pace each transfer: an active-low data-present strobe and a ready line. The direction of the port is chosen by one control input. When the port receives, the peer drives the strobe and the block drives ready. When the port sends, the block drives the strobe and the peer drives ready. The external handshake inputs and the incoming data are resynchronised by a flop chain before any edge is judged. Each transfer then follows a four-phase interlock.

On the core side, received bytes are offered with a valid/ready pair and are held until the core takes them. Bytes to send are accepted with a valid/ready pair only when the sending machine is idle and the peer is showing ready. Before the strobe falls, a programmable count of clocks holds the outgoing byte on the pins by itself. Switching direction cancels any transfer in flight and puts both handshake outputs at their resting levels.

Top module: `hs_port`

## Requirements
- R1: After reset, with `dir_out` low: `dav_n_out` is 1, `rdy_out` is 1, `rx_valid` is 0, `tx_ready` is 0 and `pin_oe` is 0.
- R2: In receive mode (`dir_out`=0), when a high-to-low change of `dav_n_in` is seen, the byte on `pin_din` is latched into `rx_data`. That byte is the one sampled on the same clock edge as the first low `dav_n_in`. `rx_valid` rises on the third rising edge after `dav_n_in` goes low.
- R3: In receive mode, `rdy_out` goes low in the cycle the byte is latched. It stays low until the core has read the byte (`rx_valid` and `rx_ready` together) and the resynchronised strobe is high again. `rdy_out` returns high on the third edge after `dav_n_in` rises, or on the read edge if that comes later.
- R4: A further strobe fall while a latched byte is still unread does not change `rx_data` or `rx_valid`.
- R5: In send mode (`dir_out`=1), a byte is taken only on an edge where `tx_valid` and `tx_ready` are both high. It appears on `pin_dout` after that edge, and `pin_dout` holds it while `dav_n_out` is low.
- R6: `dav_n_out` falls exactly N clock edges after the accept edge. N is `dly_cfg`, except that a `dly_cfg` of 0 counts as 1.
- R7: `dav_n_out` stays low while the resynchronised ready input is high. It returns high on the third rising edge after `rdy_in` goes low.
- R8: `tx_ready` stays low until the resynchronised `rdy_in` is high, so the next strobe fall waits for ready to rise again. `tx_ready` rises on the second edge after `rdy_in` rises.
- R9: On the edge after `dir_out` changes, the handshake is cancelled. `dav_n_out` is 1, `rx_valid` is 0, and `pin_oe` equals the new direction. `rdy_out` is 1 in receive mode and 0 in send mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_out | input | 1 | 1 selects send mode, 0 selects receive mode |
| dly_cfg | input | DLY_W | Clocks from byte on pins to strobe fall (0 counts as 1) |
| tx_data | input | W | Byte to send |
| tx_valid | input | 1 | Core offers a byte to send |
| tx_ready | output | 1 | Block accepts the offered byte on this edge |
| rx_data | output | W | Latched received byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_ready | input | 1 | Core takes the waiting byte |
| pin_din | input | W | Data pins, input side |
| pin_dout | output | W | Data pins, output side |
| pin_oe | output | 1 | Drive enable for the data pins |
| dav_n_in | input | 1 | Active-low strobe from the peer (receive mode) |
| dav_n_out | output | 1 | Active-low strobe to the peer (send mode) |
| rdy_in | input | 1 | Ready from the peer (send mode) |
| rdy_out | output | 1 | Ready to the peer (receive mode) |

## Verification
The bench builds the block with an 8-bit byte, a 4-bit delay field and two synchroniser stages. With these values the exact edge counts in R2, R3, R7 and R8 can be checked against fixed numbers. The 4-bit field covers the zero-delay substitution, a middle setting and a setting of seven clocks. Directed sequences push a second strobe into a busy receiver, read the byte before and after the strobe releases, and flip direction during both a receive and a send handshake. A behavioural model is compared with every output on each clock.

// File: rtl/hs_port.sv
module hs_port #(
  parameter int W     = 8,
  parameter int DLY_W = 4,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_out,
  input  logic [DLY_W-1:0] dly_cfg,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [W-1:0]     rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic [W-1:0]     pin_din,
  output logic [W-1:0]     pin_dout,
  output logic             pin_oe,
  input  logic             dav_n_in,
  output logic             dav_n_out,
  input  logic             rdy_in,
  output logic             rdy_out
);

  typedef enum logic [1:0] {ST_IDLE, ST_IN_BUSY, ST_OUT_SETUP, ST_OUT_ACK} st_t;

  st_t              st;
  logic [SYNC-1:0]  dav_sh, rdy_sh;
  logic [W-1:0]     din_sh [SYNC];
  logic             dav_d, dir_q;
  logic [DLY_W-1:0] cnt, dly_eff;
  logic             dav_s, rdy_s, dav_fall, dir_chg, tx_fire, rx_fire;

  assign dav_s    = dav_sh[SYNC-1];
  assign rdy_s    = rdy_sh[SYNC-1];
  assign dav_fall = dav_d & ~dav_s;
  assign dir_chg  = dir_q != dir_out;
  assign dly_eff  = (dly_cfg == '0) ? DLY_W'(1) : dly_cfg;
  assign tx_fire  = tx_valid & tx_ready;
  assign rx_fire  = rx_valid & rx_ready;

  assign tx_ready  = dir_q & dir_out & (st == ST_IDLE) & rdy_s;
  assign rdy_out   = ~dir_q & (st == ST_IDLE);
  assign dav_n_out = st != ST_OUT_ACK;
  assign pin_oe    = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dav_sh <= '1;
      rdy_sh <= '0;
      dav_d  <= 1'b1;
      for (int i = 0; i < SYNC; i++) din_sh[i] <= '0;
    end else begin
      dav_sh    <= {dav_sh[SYNC-2:0], dav_n_in};
      rdy_sh    <= {rdy_sh[SYNC-2:0], rdy_in};
      dav_d     <= dav_s;
      din_sh[0] <= pin_din;
      for (int i = 1; i < SYNC; i++) din_sh[i] <= din_sh[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dir_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      pin_dout <= '0;
      cnt      <= '0;
    end else begin
      dir_q <= dir_out;
      if (dir_chg) begin
        st       <= ST_IDLE;
        rx_valid <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: begin
            if (!dir_q && dav_fall) begin
              rx_data  <= din_sh[SYNC-1];
              rx_valid <= 1'b1;
              st       <= ST_IN_BUSY;
            end else if (tx_fire) begin
              pin_dout <= tx_data;
              cnt      <= dly_eff - DLY_W'(1);
              st       <= ST_OUT_SETUP;
            end
          end
          ST_IN_BUSY: begin
            if (rx_fire) rx_valid <= 1'b0;
            if (dav_s && (!rx_valid || rx_fire)) st <= ST_IDLE;
          end
          ST_OUT_SETUP: begin
            if (cnt == '0) st <= ST_OUT_ACK;
            else cnt <= cnt - DLY_W'(1);
          end
          ST_OUT_ACK: begin
            if (!rdy_s) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir_out,
  input logic         rdy_in,
  input logic         tx_ready,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic [W-1:0] rx_data,
  input logic [W-1:0] pin_dout,
  input logic         pin_oe,
  input logic         dav_n_out,
  input logic         rdy_out
);

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !dir_out && !pin_oe) |=> (rx_valid && $stable(rx_data)));

  assert_rdy_low_while_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rdy_out);

  assert_dout_stable_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dav_n_out |=> $stable(pin_dout));

  assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dav_n_out) && pin_oe) |-> !$past(rdy_in, 3));

  assert_accept_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (pin_oe && dav_n_out && dir_out));

  assert_quiet_in_receive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> dav_n_out);

  assert_no_ready_in_send_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (!rdy_out && !rx_valid));

endmodule

bind hs_port hs_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .rdy_in(rdy_in),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .pin_dout(pin_dout), .pin_oe(pin_oe),
  .dav_n_out(dav_n_out), .rdy_out(rdy_out)
);

// File: tb/hs_port_tb.sv
module hs_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int DLY_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, dir_out = 1'b0;
  logic [DLY_W-1:0] dly_cfg = 3;
  logic [W-1:0] tx_data = '0, pin_din = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, dav_n_in = 1'b1, rdy_in = 1'b0;
  logic tx_ready, rx_valid, pin_oe, dav_n_out, rdy_out;
  logic [W-1:0] rx_data, pin_dout;

  hs_port #(.W(W), .DLY_W(DLY_W), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .dly_cfg(dly_cfg),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .pin_din(pin_din), .pin_dout(pin_dout), .pin_oe(pin_oe),
    .dav_n_in(dav_n_in), .dav_n_out(dav_n_out), .rdy_in(rdy_in), .rdy_out(rdy_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 holding a received byte, 2 counting, 3 strobe low
  int m_phase = 0, m_left = 0, m_dir = 0, m_rxv = 0, m_rxd = 0, m_dout = 0;
  int dq[$] = '{1, 1, 1};
  int rq[$] = '{0, 0, 0};
  int iq[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_dir = 0; m_rxv = 0; m_rxd = 0; m_dout = 0;
      dq = '{1, 1, 1}; rq = '{0, 0, 0}; iq = '{0, 0, 0};
    end else begin
      int seen_hi, fell, peer_rdy, take, eff;
      seen_hi  = dq[1];
      fell     = dq[2] && !dq[1];
      peer_rdy = rq[1];
      take     = tx_valid && m_dir && dir_out && m_phase == 0 && peer_rdy;
      eff      = (dly_cfg == 0) ? 1 : int'(dly_cfg);
      if (m_dir != int'(dir_out)) begin
        m_phase = 0; m_rxv = 0;
      end else if (m_phase == 0) begin
        if (!m_dir && fell) begin m_rxd = iq[1]; m_rxv = 1; m_phase = 1; end
        else if (take) begin m_dout = tx_data; m_left = eff - 1; m_phase = 2; end
      end else if (m_phase == 1) begin
        int rd;
        rd = m_rxv && rx_ready;
        if (rd) m_rxv = 0;
        if (seen_hi && (m_rxv == 0)) m_phase = 0;
      end else if (m_phase == 2) begin
        if (m_left == 0) m_phase = 3; else m_left--;
      end else begin
        if (!peer_rdy) m_phase = 0;
      end
      m_dir = dir_out;
      dq.push_front(dav_n_in); void'(dq.pop_back());
      rq.push_front(rdy_in);   void'(rq.pop_back());
      iq.push_front(pin_din);  void'(iq.pop_back());
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      int e_txr;
      e_txr = m_dir && dir_out && m_phase == 0 && rq[1];
      chk(tx_ready == e_txr, "R8 lockstep tx_ready", tx_ready, e_txr);
      chk(rx_valid == m_rxv, "R2 lockstep rx_valid", rx_valid, m_rxv);
      chk(rx_data == m_rxd, "R2 lockstep rx_data", rx_data, m_rxd);
      chk(rdy_out == (!m_dir && m_phase == 0), "R3 lockstep rdy_out", rdy_out, !m_dir && m_phase == 0);
      chk(pin_dout == m_dout, "R5 lockstep pin_dout", pin_dout, m_dout);
      chk(dav_n_out == (m_phase != 3), "R6 lockstep dav_n_out", dav_n_out, m_phase != 3);
      chk(pin_oe == m_dir, "R9 lockstep pin_oe", pin_oe, m_dir);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic out_xfer(input logic [W-1:0] d, input int dly, input int expd);
    int k;
    dly_cfg = dly; tx_data = d; tx_valid = 1'b1;
    for (int i = 0; i < 50 && !tx_ready; i++) step(1);
    step(1);
    tx_valid = 1'b0;
    chk(pin_dout == d, "R5 byte on pins after accept", pin_dout, d);
    k = 0;
    while (dav_n_out && k < 40) begin step(1); k++; end
    chk(k == expd, "R6 strobe delay", k, expd);
    step(4);
    chk(dav_n_out == 1'b0, "R7 strobe held while ready high", dav_n_out, 0);
    rdy_in = 1'b0;
    step(2);
    chk(dav_n_out == 1'b0, "R7 strobe still low 2 edges after ack", dav_n_out, 0);
    step(1);
    chk(dav_n_out == 1'b1, "R7 strobe released 3 edges after ack", dav_n_out, 1);
    tx_valid = 1'b1; tx_data = ~d;
    step(4);
    chk(tx_ready == 1'b0, "R8 no accept while ready low", tx_ready, 0);
    chk(pin_dout == d, "R8 pins unchanged while ready low", pin_dout, d);
    rdy_in = 1'b1;
    step(1);
    chk(tx_ready == 1'b0, "R8 ready not yet through sync", tx_ready, 0);
    step(1);
    chk(tx_ready == 1'b1, "R8 accept reopens", tx_ready, 1);
    tx_valid = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(dav_n_out == 1'b1, "R1 reset dav_n_out", dav_n_out, 1);
    chk(rdy_out == 1'b1, "R1 reset rdy_out", rdy_out, 1);
    chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b0, "R1 reset tx_ready", tx_ready, 0);
    chk(pin_oe == 1'b0, "R1 reset pin_oe", pin_oe, 0);

    pin_din = 8'hA5; dav_n_in = 1'b0;
    step(1);
    pin_din = 8'h00;
    step(1);
    chk(rx_valid == 1'b0, "R2 not yet latched", rx_valid, 0);
    step(1);
    chk(rx_valid == 1'b1, "R2 valid on third edge", rx_valid, 1);
    chk(rx_data == 8'hA5, "R2 byte latched", rx_data, 8'hA5);
    chk(rdy_out == 1'b0, "R3 ready drops on latch", rdy_out, 0);
    step(2);
    dav_n_in = 1'b1; pin_din = 8'h3C;
    step(3);
    dav_n_in = 1'b0;
    step(4);
    dav_n_in = 1'b1;
    step(4);
    chk(rx_data == 8'hA5, "R4 second strobe ignored data", rx_data, 8'hA5);
    chk(rx_valid == 1'b1, "R4 second strobe ignored valid", rx_valid, 1);
    chk(rdy_out == 1'b0, "R3 ready low while unread", rdy_out, 0);
    rx_ready = 1'b1;
    step(1);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R3 read clears valid", rx_valid, 0);
    chk(rdy_out == 1'b1, "R3 ready back after read", rdy_out, 1);

    pin_din = 8'h5A; dav_n_in = 1'b0;
    step(3);
    chk(rx_data == 8'h5A, "R2 second byte", rx_data, 8'h5A);
    rx_ready = 1'b1;
    step(1);
    rx_ready = 1'b0;
    chk(rdy_out == 1'b0, "R3 ready waits for strobe release", rdy_out, 0);
    step(2);
    dav_n_in = 1'b1;
    step(2);
    chk(rdy_out == 1'b0, "R3 ready low 2 edges after release", rdy_out, 0);
    step(1);
    chk(rdy_out == 1'b1, "R3 ready high 3 edges after release", rdy_out, 1);

    rdy_in = 1'b1; dir_out = 1'b1;
    step(3);
    chk(pin_oe == 1'b1, "R9 send mode drives pins", pin_oe, 1);
    chk(rdy_out == 1'b0, "R9 ready output quiet in send mode", rdy_out, 0);
    out_xfer(8'hC3, 3, 3);
    out_xfer(8'h96, 0, 1);
    out_xfer(8'h11, 7, 7);

    dly_cfg = 1; tx_data = 8'h77; tx_valid = 1'b1;
    for (int i = 0; i < 50 && !tx_ready; i++) step(1);
    step(1);
    tx_valid = 1'b0;
    step(1);
    chk(dav_n_out == 1'b0, "R6 strobe low before direction flip", dav_n_out, 0);
    dir_out = 1'b0;
    step(1);
    chk(dav_n_out == 1'b1, "R9 flip releases strobe", dav_n_out, 1);
    chk(pin_oe == 1'b0, "R9 flip releases pins", pin_oe, 0);
    chk(rdy_out == 1'b1, "R9 flip to receive shows ready", rdy_out, 1);

    pin_din = 8'h42; dav_n_in = 1'b0;
    step(3);
    chk(rx_valid == 1'b1, "R2 byte before flip", rx_valid, 1);
    dir_out = 1'b1;
    step(1);
    chk(rx_valid == 1'b0, "R9 flip drops pending byte", rx_valid, 0);
    chk(rdy_out == 1'b0, "R9 flip to send quiets ready", rdy_out, 0);
    dav_n_in = 1'b1;
    step(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule